// File: doc/BRIEF.md
# Calendar Counter with BCD Mode

This block keeps a calendar date made of a day, a month and a two-digit year. Each one-cycle day strobe moves the date forward by one day. The block wraps the day at the true length of the current month, moves to the next month, and at the end of December moves to the next year. February is 29 days long when the year is a multiple of four and 28 days long otherwise.

A mode input sets how all three fields are encoded. When the input is 0, the fields hold plain binary values. When it is 1, they hold packed BCD, with one decimal digit per nibble. The rollover rules are the same in both encodings. Changing the mode does not rewrite the stored fields. After a mode change, software loads a fresh date written in the new encoding.

A synchronous load port sets all three fields at once. A load always wins over a day strobe in the same cycle.

Top module: `cal_date_counter`

## Requirements
- R1: While reset is asserted, the outputs read day 0x01, month 0x01 and year 0x00 (the same bit patterns in both encodings).
- R2: With load high at a clock edge, the three load values appear on the outputs after that edge, and any day strobe in that same cycle is ignored.
- R3: With neither load nor day strobe, all three outputs keep their values.
- R4: On a day strobe, the day increases by one until it reaches the month's last day. Months 4, 6, 9 and 11 end at day 30, and months 1, 3, 5, 7, 8, 10 and 12 end at day 31. After the last day, the day becomes 1 and the month increases by one.
- R5: With mode 1 (BCD), each nibble carries from 9 into the next digit: day 0x09 becomes 0x10, day 0x19 becomes 0x20, and month 0x09 becomes 0x10.
- R6: With mode 1 in December (0x12), the day runs 0x29, 0x30, 0x31 with no skipped value, and after 0x31 the date becomes 0x01/0x01 with the year increased by one.
- R7: In February, day 28 moves to day 29 when the year is divisible by 4, and moves to March 1 otherwise. Day 29 always moves to March 1. This holds in both encodings.
- R8: After December 31, the month returns to 1 and the year increases by one. Year 99 (0x99 in BCD) wraps to 0.
- R9: Toggling the mode input without a load or a strobe leaves the stored bit patterns of all three outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| day_tick_i | input | 1 | One-cycle strobe that advances the date by one day |
| bcd_mode_i | input | 1 | Encoding: 0 = binary, 1 = packed BCD |
| load_i | input | 1 | Writes the three load fields at the next edge |
| load_day_i | input | 8 | Day value to load |
| load_mon_i | input | 8 | Month value to load |
| load_year_i | input | 8 | Year value to load |
| day_o | output | 8 | Current day |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |

## Verification
A load and a day strobe can arrive in the same cycle. The bench raises both at one edge, using a load date whose next day would give a different result. It then expects exactly the loaded date, and a checker property compares each output field with the load value from the previous cycle. A mode change and a rollover can also meet. The vector table covers this by switching the encoding just before each strobe and checking the carry of both month-end and year-end in each encoding.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned F_DAY = 0;
  localparam int unsigned F_MON = 1;
  localparam int unsigned F_YEAR = 2;

  typedef enum logic {
    ENC_BIN = 1'b0,
    ENC_BCD = 1'b1
  } enc_e;

  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/cal_field_decode.sv
module cal_field_decode #(
  parameter int unsigned W = 8
) (
  input  logic         bcd_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] bin_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0] tens_w;
  logic [W-1:0] ones_w;

  always_comb begin
    tens_w = W'(raw_i[W-1:NIB]);
    ones_w = W'(raw_i[NIB-1:0]);
    if (bcd_i) bin_o = tens_w * W'(10) + ones_w;
    else       bin_o = raw_i;
  end
endmodule

// File: rtl/cal_field_encode.sv
module cal_field_encode #(
  parameter int unsigned W = 8
) (
  input  logic         bcd_i,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] raw_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0] tens_w;
  logic [W-1:0] ones_w;

  always_comb begin
    tens_w = bin_i / W'(10);
    ones_w = bin_i % W'(10);
    if (bcd_i) raw_o = {tens_w[NIB-1:0], ones_w[NIB-1:0]};
    else       raw_o = bin_i;
  end
endmodule

// File: rtl/cal_month_last.sv
module cal_month_last #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] mon_bin_i,
  input  logic [W-1:0] year_bin_i,
  output logic [W-1:0] last_day_o
);
  logic leap_w;

  always_comb begin
    leap_w = (year_bin_i[1:0] == 2'b00);
    case (mon_bin_i)
      W'(4), W'(6), W'(9), W'(11): last_day_o = W'(30);
      W'(2):                       last_day_o = leap_w ? W'(29) : W'(28);
      default:                     last_day_o = W'(31);
    endcase
  end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
#(
  parameter int unsigned YEAR_LAST = 99
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               day_tick_i,
  input  logic               bcd_mode_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_day_i,
  input  logic [FIELD_W-1:0] load_mon_i,
  input  logic [FIELD_W-1:0] load_year_i,
  output logic [FIELD_W-1:0] day_o,
  output logic [FIELD_W-1:0] mon_o,
  output logic [FIELD_W-1:0] year_o
);
  localparam int unsigned W = FIELD_W;
  localparam int unsigned MONTHS = 12;
  localparam field_t ONE = field_t'(1);

  logic   rst_sync_n;
  enc_e   enc_w;
  field_t cur_q   [NUM_FIELDS];
  field_t nxt_d   [NUM_FIELDS];
  field_t cur_bin [NUM_FIELDS];
  field_t adv_bin [NUM_FIELDS];
  field_t adv_raw [NUM_FIELDS];
  field_t load_w  [NUM_FIELDS];
  field_t last_day_w;
  logic   upd_en;

  cal_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  assign enc_w = enc_e'(bcd_mode_i);
  assign load_w[F_DAY]  = load_day_i;
  assign load_w[F_MON]  = load_mon_i;
  assign load_w[F_YEAR] = load_year_i;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    cal_field_decode #(.W(W)) u_dec (
      .bcd_i(enc_w == ENC_BCD),
      .raw_i(cur_q[g]),
      .bin_o(cur_bin[g])
    );
    cal_field_encode #(.W(W)) u_enc (
      .bcd_i(enc_w == ENC_BCD),
      .bin_i(adv_bin[g]),
      .raw_o(adv_raw[g])
    );
  end

  cal_month_last #(.W(W)) u_last (
    .mon_bin_i (cur_bin[F_MON]),
    .year_bin_i(cur_bin[F_YEAR]),
    .last_day_o(last_day_w)
  );

  // Next date in binary: day, then month carry, then year carry
  always_comb begin
    adv_bin[F_DAY]  = cur_bin[F_DAY] + ONE;
    adv_bin[F_MON]  = cur_bin[F_MON];
    adv_bin[F_YEAR] = cur_bin[F_YEAR];
    if (cur_bin[F_DAY] >= last_day_w) begin
      adv_bin[F_DAY] = ONE;
      if (cur_bin[F_MON] >= field_t'(MONTHS)) begin
        adv_bin[F_MON] = ONE;
        if (cur_bin[F_YEAR] >= field_t'(YEAR_LAST)) adv_bin[F_YEAR] = '0;
        else                                         adv_bin[F_YEAR] = cur_bin[F_YEAR] + ONE;
      end else begin
        adv_bin[F_MON] = cur_bin[F_MON] + ONE;
      end
    end
  end

  // Load has priority over the day strobe
  always_comb begin
    upd_en = load_i | day_tick_i;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      nxt_d[i] = load_i ? load_w[i] : adv_raw[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_q[F_DAY]  <= ONE;
      cur_q[F_MON]  <= ONE;
      cur_q[F_YEAR] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < NUM_FIELDS; i++) cur_q[i] <= nxt_d[i];
    end
  end

  assign day_o  = cur_q[F_DAY];
  assign mon_o  = cur_q[F_MON];
  assign year_o = cur_q[F_YEAR];
endmodule

// File: rtl/cal_date_counter_chk.sv
module cal_date_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         day_tick_i,
  input logic         bcd_mode_i,
  input logic         load_i,
  input logic [W-1:0] load_day_i,
  input logic [W-1:0] load_mon_i,
  input logic [W-1:0] load_year_i,
  input logic [W-1:0] day_o,
  input logic [W-1:0] mon_o,
  input logic [W-1:0] year_o
);
  logic adv_w;
  logic feb_end_w;
  logic dec_w;

  assign adv_w     = day_tick_i && !load_i;
  assign feb_end_w = (mon_o == W'(2)) &&
                     ((bcd_mode_i && day_o == W'(8'h29)) || (!bcd_mode_i && day_o == W'(29)));
  assign dec_w     = (bcd_mode_i && mon_o == W'(8'h12)) || (!bcd_mode_i && mon_o == W'(12));

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (day_o == $past(load_day_i)) && (mon_o == $past(load_mon_i)) &&
               (year_o == $past(load_year_i)));

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !day_tick_i) |=> $stable(day_o) && $stable(mon_o) && $stable(year_o));

  a_r4_day_or_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_w |=> (day_o == W'(1)) || ((mon_o == $past(mon_o)) && (year_o == $past(year_o))));

  a_r7_feb_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && feb_end_w) |=> (mon_o == W'(3)) && (day_o == W'(1)));

  a_r8_year_only_after_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && !dec_w) |=> $stable(year_o));
endmodule

bind cal_date_counter cal_date_counter_chk #(.W(cal_pkg::FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .day_tick_i (day_tick_i),
  .bcd_mode_i (bcd_mode_i),
  .load_i     (load_i),
  .load_day_i (load_day_i),
  .load_mon_i (load_mon_i),
  .load_year_i(load_year_i),
  .day_o      (day_o),
  .mon_o      (mon_o),
  .year_o     (year_o)
);

// File: tb/test_cal_date_counter.sv
module test_cal_date_counter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 20;
  localparam int  WATCHDOG_CYCLES = 100000;

  // {req[4], bcd[1], day, mon, year, exp_day, exp_mon, exp_year}
  localparam logic [52:0] VEC [NV] = '{
    {4'd4, 1'b0, 8'd5,  8'd4,  8'd21, 8'd6,  8'd4,  8'd21},   // R4
    {4'd4, 1'b0, 8'd30, 8'd4,  8'd21, 8'd1,  8'd5,  8'd21},   // R4
    {4'd4, 1'b0, 8'd30, 8'd5,  8'd21, 8'd31, 8'd5,  8'd21},   // R4
    {4'd4, 1'b0, 8'd30, 8'd11, 8'd5,  8'd1,  8'd12, 8'd5},    // R4
    {4'd8, 1'b0, 8'd31, 8'd12, 8'd21, 8'd1,  8'd1,  8'd22},   // R8
    {4'd8, 1'b0, 8'd31, 8'd12, 8'd99, 8'd1,  8'd1,  8'd0},    // R8
    {4'd7, 1'b0, 8'd28, 8'd2,  8'd24, 8'd29, 8'd2,  8'd24},   // R7
    {4'd7, 1'b0, 8'd29, 8'd2,  8'd24, 8'd1,  8'd3,  8'd24},   // R7
    {4'd7, 1'b0, 8'd28, 8'd2,  8'd23, 8'd1,  8'd3,  8'd23},   // R7
    {4'd5, 1'b1, 8'h09, 8'h03, 8'h21, 8'h10, 8'h03, 8'h21},   // R5
    {4'd5, 1'b1, 8'h19, 8'h07, 8'h21, 8'h20, 8'h07, 8'h21},   // R5
    {4'd5, 1'b1, 8'h30, 8'h09, 8'h10, 8'h01, 8'h10, 8'h10},   // R5
    {4'd6, 1'b1, 8'h29, 8'h12, 8'h21, 8'h30, 8'h12, 8'h21},   // R6
    {4'd6, 1'b1, 8'h30, 8'h12, 8'h21, 8'h31, 8'h12, 8'h21},   // R6
    {4'd6, 1'b1, 8'h31, 8'h12, 8'h21, 8'h01, 8'h01, 8'h22},   // R6
    {4'd7, 1'b1, 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24},   // R7
    {4'd7, 1'b1, 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23},   // R7
    {4'd7, 1'b1, 8'h29, 8'h02, 8'h96, 8'h01, 8'h03, 8'h96},   // R7
    {4'd8, 1'b1, 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00},   // R8
    {4'd4, 1'b1, 8'h31, 8'h01, 8'h00, 8'h01, 8'h02, 8'h00}    // R4
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, bcd, load;
  logic [7:0] ld_day, ld_mon, ld_year;
  logic [7:0] day, mon, year;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_date_counter i_cal_date_counter (
    .clk_i(clk), .rst_ni(rst_n), .day_tick_i(tick), .bcd_mode_i(bcd),
    .load_i(load), .load_day_i(ld_day), .load_mon_i(ld_mon), .load_year_i(ld_year),
    .day_o(day), .mon_o(mon), .year_o(year)
  );

  task automatic check(string tag, logic [7:0] ed, logic [7:0] em, logic [7:0] ey);
    checks++;
    if (day !== ed || mon !== em || year !== ey) begin
      errors++;
      $display("FAIL %s: got %h/%h/%h expected %h/%h/%h", tag, day, mon, year, ed, em, ey);
    end
  endtask

  task automatic do_load(logic [7:0] d, logic [7:0] m, logic [7:0] y);
    @(negedge clk);
    load = 1'b1; ld_day = d; ld_mon = m; ld_year = y;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; bcd = 1'b0; load = 1'b0;
    ld_day = '0; ld_mon = '0; ld_year = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h01, 8'h01, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 8'h01, 8'h01, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bcd = VEC[i][48];
      do_load(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
      do_tick();
      check($sformatf("R%0d vector %0d", VEC[i][52:49], i),
            VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: load and strobe in the same cycle, load wins
    bcd = 1'b0;
    @(negedge clk);
    load = 1'b1; tick = 1'b1; ld_day = 8'd30; ld_mon = 8'd6; ld_year = 8'd40;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    check("R2 load beats tick", 8'd30, 8'd6, 8'd40);

    // R3: no strobe, no change
    repeat (5) @(negedge clk);
    check("R3 idle hold", 8'd30, 8'd6, 8'd40);

    // R9: mode toggling leaves stored patterns untouched
    do_load(8'd20, 8'd10, 8'd15);
    bcd = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 to bcd", 8'd20, 8'd10, 8'd15);
    bcd = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 back to binary", 8'd20, 8'd10, 8'd15);

    // R6: walk December in BCD through year end
    bcd = 1'b1;
    do_load(8'h28, 8'h12, 8'h45);
    do_tick(); check("R6 walk 29", 8'h29, 8'h12, 8'h45);
    do_tick(); check("R6 walk 30", 8'h30, 8'h12, 8'h45);
    do_tick(); check("R6 walk 31", 8'h31, 8'h12, 8'h45);
    do_tick(); check("R6 walk new year", 8'h01, 8'h01, 8'h46);

    // R4: full 31-day January in binary ends at Feb 1
    bcd = 1'b0;
    do_load(8'd1, 8'd1, 8'd7);
    for (int k = 0; k < 31; k++) do_tick();
    check("R4 january length", 8'd1, 8'd2, 8'd7);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 8'h01, 8'h01, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule